// File: doc/BRIEF.md
# Tug-of-War Game Controller

This block is the core of a two-player button race. A row of nine lamps shows one lit position. It starts on the centre lamp and is pulled toward whichever player presses faster. Each player supplies a one-cycle press pulse that has already been debounced. A per-player prescaler turns a set number of presses into one step of the rope. When the lit position lands on an end lamp, that player wins the round. The block then freezes and ignores both players until the round is restarted.

The block keeps a decimal count of the rounds each player has won, for a numeric readout. A round restart recentres the rope and keeps both counts. A full clear also zeroes the counts. The block also divides the 50 MHz system clock into a 1 kHz one-cycle tick that paces an external display scanner.

The round sequencer has three states. `ST_PLAY` is the live round. `ST_LEFT_WON` and `ST_RIGHT_WON` are the frozen outcomes. Its transitions are:
- `ST_PLAY -> ST_LEFT_WON` on a left step from lamp 1.
- `ST_PLAY -> ST_RIGHT_WON` on a right step from lamp 7.
- Any state `-> ST_PLAY` with the rope on the centre lamp, on restart or full clear.
- Every other case holds the current state.

Top module: `tug_war_core`

## Requirements
- R1: After reset only lamp index 4 is lit, `frozen` is 0, `winner` is 2'b00 and both tallies are 0.
- R2: Exactly one lamp is lit at all times; the lamp outputs are active-high and one-hot, with lamp index i on bit i.
- R3: A player's step is produced on every PRESSES_PER_STEP-th accepted press of that player (default 10). Fewer presses leave the lamps unchanged.
- R4: Each step moves the lit lamp by exactly one position: a left step lowers the index and a right step raises it.
- R5: Reaching index 0 sets `winner` to 2'b01 (left), and reaching index 8 sets `winner` to 2'b10 (right). In both cases `frozen` is 1 from the same clock edge on.
- R6: While frozen, presses from both players leave the lamps, `winner` and the tallies unchanged.
- R7: `round_restart` recentres the lamp, clears `frozen` and `winner`, and discards any partial press counts, but keeps both tallies.
- R8: `clear_all` does everything a restart does and also zeroes both tallies.
- R9: Each tally is BCD in the range 0 to 9 and saturates at 9.
- R10: If both players' steps land in the same clock cycle, they cancel and the lamp does not move; both partial press counts still restart from zero.
- R11: `scan_tick` is high for a single cycle once every SCAN_DIV cycles (default 50000, giving 1 kHz at 50 MHz).
- R12: A round win adds exactly one to the winner's tally on the edge where the win is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| press_l | input | 1 | Left player press pulse, one cycle per press |
| press_r | input | 1 | Right player press pulse, one cycle per press |
| round_restart | input | 1 | Synchronous restart of the round; keeps tallies |
| clear_all | input | 1 | Synchronous restart that also zeroes tallies |
| lamps | output | 9 | One-hot lamp row, bit i is lamp i |
| frozen | output | 1 | High while a round is won and locked |
| winner | output | 2 | 00 none, 01 left, 10 right |
| tally_l | output | 4 | Left player rounds won, BCD |
| tally_r | output | 4 | Right player rounds won, BCD |
| scan_tick | output | 1 | One-cycle display scan enable tick |

## Verification
The bench stops one press short of a step and then adds the last press. This catches a prescaler that steps one press early or late. It restarts mid-count and then presses three more times, which exposes a prescaler that keeps its partial count across a restart. It fires both players' final presses in the same cycle, which shows a design that lets one side win the tie. It presses hard after a win, keeps winning until the tally is past nine, and times the gap between scan ticks. A design that keeps moving when frozen, wraps its tally to zero, or miscounts its divider would fail these checks.

// File: rtl/tow_pkg.sv
`timescale 1ns/1ps
package tow_pkg;
    typedef enum logic [1:0] {
        ST_PLAY      = 2'd0,
        ST_LEFT_WON  = 2'd1,
        ST_RIGHT_WON = 2'd2
    } round_e;

    localparam logic [1:0] WIN_NONE  = 2'b00;
    localparam logic [1:0] WIN_LEFT  = 2'b01;
    localparam logic [1:0] WIN_RIGHT = 2'b10;
endpackage

// File: rtl/press_divider.sv
`timescale 1ns/1ps
module press_divider #(
    parameter int PRESSES_PER_STEP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic press,
    output logic step
);
    localparam int CW = (PRESSES_PER_STEP > 1) ? $clog2(PRESSES_PER_STEP) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESSES_PER_STEP - 1);

    logic [CW-1:0] cnt;

    assign step = press && enable && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (press && enable)
            cnt <= step ? '0 : cnt + 1'b1;
    end

    AST_PRESS_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R3
    AST_PRESS_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(cnt)); // R6
endmodule

// File: rtl/rope_fsm.sv
`timescale 1ns/1ps
module rope_fsm
    import tow_pkg::*;
#(
    parameter int LAMPS = 9,
    localparam int PW = $clog2(LAMPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step_l,
    input  logic          step_r,
    output logic [PW-1:0] pos,
    output logic          frozen,
    output logic [1:0]    winner,
    output logic          win_l,
    output logic          win_r
);
    localparam logic [PW-1:0] CENTER = PW'((LAMPS - 1) / 2);
    localparam logic [PW-1:0] LAST   = PW'(LAMPS - 1);

    round_e        state, state_d;
    logic [PW-1:0] pos_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PLAY;
            pos   <= CENTER;
        end else begin
            state <= state_d;
            pos   <= pos_d;
        end
    end

    always_comb begin
        state_d = state;
        pos_d   = pos;
        win_l   = 1'b0;
        win_r   = 1'b0;
        if (clear) begin
            state_d = ST_PLAY;
            pos_d   = CENTER;
        end else begin
            unique case (state)
                ST_PLAY: begin
                    if (step_l && !step_r) begin
                        pos_d = pos - 1'b1;
                        if (pos == PW'(1)) begin
                            state_d = ST_LEFT_WON;
                            win_l   = 1'b1;
                        end
                    end else if (step_r && !step_l) begin
                        pos_d = pos + 1'b1;
                        if (pos == LAST - 1'b1) begin
                            state_d = ST_RIGHT_WON;
                            win_r   = 1'b1;
                        end
                    end
                end
                ST_LEFT_WON, ST_RIGHT_WON: ;
                default: state_d = ST_PLAY;
            endcase
        end
    end

    always_comb begin
        frozen = 1'b0;
        winner = WIN_NONE;
        unique case (state)
            ST_PLAY: ;
            ST_LEFT_WON: begin
                frozen = 1'b1;
                winner = WIN_LEFT;
            end
            ST_RIGHT_WON: begin
                frozen = 1'b1;
                winner = WIN_RIGHT;
            end
            default: ;
        endcase
    end

    AST_ONE_LAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (pos == $past(pos) || pos == $past(pos) + 1'b1 || pos + 1'b1 == $past(pos))); // R4
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PLAY && !clear) |=> ($stable(pos) && $stable(state))); // R6
    AST_LEFT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEFT_WON) |-> (pos == '0)); // R5
    AST_RIGHT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RIGHT_WON) |-> (pos == LAST)); // R5
    AST_TIE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && step_l && step_r && !clear) |=> $stable(pos)); // R10
    AST_RESTART_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pos == CENTER && state == ST_PLAY)); // R7
endmodule

// File: rtl/win_tally.sv
`timescale 1ns/1ps
module win_tally #(
    parameter int MAX_COUNT = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       win,
    output logic [3:0] count
);
    localparam logic [3:0] TOP = 4'(MAX_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (win && count != TOP)
            count <= count + 1'b1;
    end

    AST_TALLY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP); // R9
    AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !clear && count < TOP) |=> (count == $past(count) + 1'b1)); // R12
    AST_TALLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R8
endmodule

// File: rtl/scan_divider.sv
`timescale 1ns/1ps
module scan_divider #(
    parameter int SCAN_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCAN_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11
endmodule

// File: rtl/tug_war_core.sv
`timescale 1ns/1ps
module tug_war_core #(
    parameter int LAMPS            = 9,
    parameter int PRESSES_PER_STEP = 10,
    parameter int SCAN_DIV         = 50000,
    localparam int PW = $clog2(LAMPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             press_l,
    input  logic             press_r,
    input  logic             round_restart,
    input  logic             clear_all,
    output logic [LAMPS-1:0] lamps,
    output logic             frozen,
    output logic [1:0]       winner,
    output logic [3:0]       tally_l,
    output logic [3:0]       tally_r,
    output logic             scan_tick
);
    logic          restart_any;
    logic          step_l, step_r;
    logic          win_l, win_r;
    logic [PW-1:0] pos;

    assign restart_any = round_restart || clear_all;

    press_divider #(.PRESSES_PER_STEP(PRESSES_PER_STEP)) u_div_l (
        .clk(clk), .rst_n(rst_n), .clear(restart_any),
        .enable(!frozen), .press(press_l), .step(step_l)
    );

    press_divider #(.PRESSES_PER_STEP(PRESSES_PER_STEP)) u_div_r (
        .clk(clk), .rst_n(rst_n), .clear(restart_any),
        .enable(!frozen), .press(press_r), .step(step_r)
    );

    rope_fsm #(.LAMPS(LAMPS)) u_rope (
        .clk(clk), .rst_n(rst_n), .clear(restart_any),
        .step_l(step_l), .step_r(step_r), .pos(pos),
        .frozen(frozen), .winner(winner), .win_l(win_l), .win_r(win_r)
    );

    win_tally u_tally_l (
        .clk(clk), .rst_n(rst_n), .clear(clear_all), .win(win_l), .count(tally_l)
    );

    win_tally u_tally_r (
        .clk(clk), .rst_n(rst_n), .clear(clear_all), .win(win_r), .count(tally_r)
    );

    scan_divider #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick(scan_tick)
    );

    for (genvar i = 0; i < LAMPS; i++) begin : g_lamp
        assign lamps[i] = (pos == PW'(i));
    end

    AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lamps) == 1); // R2
    AST_FROZEN_TALLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clear_all) |=> ($stable(tally_l) && $stable(tally_r))); // R6
endmodule

// File: tb/tug_war_core_test.sv
`timescale 1ns/1ps
module tug_war_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       press_l = 1'b0, press_r = 1'b0;
    logic       round_restart = 1'b0, clear_all = 1'b0;
    logic [8:0] lamps;
    logic       frozen;
    logic [1:0] winner;
    logic [3:0] tally_l, tally_r;
    logic       scan_tick;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tug_war_core uut (
        .clk(clk), .rst_n(rst_n), .press_l(press_l), .press_r(press_r),
        .round_restart(round_restart), .clear_all(clear_all),
        .lamps(lamps), .frozen(frozen), .winner(winner),
        .tally_l(tally_l), .tally_r(tally_r), .scan_tick(scan_tick)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic check_lamp(input string req, input int idx);
        check(req, int'(lamps), 1 << idx);
        check("R2", $countones(lamps), 1);
    endtask

    task automatic press(input bit left, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (left) press_l = 1'b1; else press_r = 1'b1;
            @(negedge clk);
            press_l = 1'b0;
            press_r = 1'b0;
        end
    endtask

    task automatic restart();
        @(negedge clk) round_restart = 1'b1;
        @(negedge clk) round_restart = 1'b0;
    endtask

    task automatic t_reset();
        check_lamp("R1", 4);
        check("R1", int'(frozen), 0);
        check("R1", int'(winner), 0);
        check("R1", int'(tally_l), 0);
        check("R1", int'(tally_r), 0);
    endtask

    task automatic t_prescale();
        press(1, 9);
        check_lamp("R3", 4);
        press(1, 1);
        check_lamp("R4", 3);
        press(0, 10);
        check_lamp("R3", 4);
        press(0, 10);
        check_lamp("R4", 5);
        restart();
    endtask

    task automatic t_partial_restart();
        press(1, 7);
        restart();
        check_lamp("R7", 4);
        press(1, 3);
        check_lamp("R7", 4);
        press(1, 7);
        check_lamp("R7", 3);
        restart();
    endtask

    task automatic t_tie();
        press(1, 9);
        press(0, 9);
        check_lamp("R10", 4);
        @(negedge clk);
        press_l = 1'b1; press_r = 1'b1;
        @(negedge clk);
        press_l = 1'b0; press_r = 1'b0;
        check_lamp("R10", 4);
        press(1, 9);
        check_lamp("R10", 4);
        press(1, 1);
        check_lamp("R10", 3);
        restart();
    endtask

    task automatic t_left_win();
        press(1, 39);
        check("R5", int'(frozen), 0);
        press(1, 1);
        check_lamp("R5", 0);
        check("R5", int'(winner), 1);
        check("R5", int'(frozen), 1);
        check("R12", int'(tally_l), 1);
        press(0, 40);
        press(1, 10);
        check_lamp("R6", 0);
        check("R6", int'(winner), 1);
        check("R6", int'(tally_l), 1);
        check("R6", int'(tally_r), 0);
        restart();
        check_lamp("R7", 4);
        check("R7", int'(frozen), 0);
        check("R7", int'(winner), 0);
        check("R7", int'(tally_l), 1);
    endtask

    task automatic t_right_win();
        press(0, 40);
        check_lamp("R5", 8);
        check("R5", int'(winner), 2);
        check("R12", int'(tally_r), 1);
        check("R12", int'(tally_l), 1);
        restart();
    endtask

    task automatic t_saturate();
        for (int w = 0; w < 8; w++) begin
            press(1, 40);
            restart();
        end
        check("R9", int'(tally_l), 9);
        press(1, 40);
        check("R9", int'(winner), 1);
        check("R9", int'(tally_l), 9);
        restart();
    endtask

    task automatic t_clear();
        press(0, 20);
        @(negedge clk) clear_all = 1'b1;
        @(negedge clk) clear_all = 1'b0;
        check_lamp("R8", 4);
        check("R8", int'(tally_l), 0);
        check("R8", int'(tally_r), 0);
        check("R8", int'(winner), 0);
    endtask

    task automatic t_tick();
        int gap = 0;
        int guard = 0;
        while (!scan_tick && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check("R11", int'(scan_tick), 0);
        gap = 1;
        while (!scan_tick && gap < 60000) begin
            @(negedge clk);
            gap++;
        end
        check("R11", gap, 50000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_partial_restart();
        t_tie();
        t_left_win();
        t_right_win();
        t_saturate();
        t_clear();
        t_tick();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule